// File: doc/BRIEF.md
# Embedded Operation Busy-Status Monitor

This block sits between a flash array read path and the host bus. It covers the span during which the flash runs an internally timed byte program or erase. A start pulse carries the operation kind and, for a program, the most significant bit of the byte being written. From then on the block counts system clock cycles on its own. No other timing input is needed. While the count runs, every host read returns a status byte in place of array data.

The status byte has two indicators that work side by side. Bit 7 is a data-polling bit: it holds the inverse of the programmed byte's top bit, or 0 during an erase, which is the inverse of the erased value 1. Bit 6 is a toggle bit: it changes value on each read strobe accepted while busy. When the count expires, the busy flag drops and a one-cycle completion pulse is given. Reads then pass array data through unchanged on all eight bits.

Top module: `emb_op_status`

## Requirements
- R1: After synchronous reset, `busy_o` and `done_o` are 0 and reads pass array data through.
- R2: While not busy, `rd_data_o` equals `array_data_i` on every bit.
- R3: A start accepted while idle raises `busy_o` from the next cycle. It stays high for exactly PROG_CYCLES cycles when `op_erase_i` = 0 (program), or ERASE_CYCLES cycles when `op_erase_i` = 1 (erase).
- R4: While a program is busy, `rd_data_o[7]` equals the inverse of the `prog_msb_i` value captured at start.
- R5: While an erase is busy, `rd_data_o[7]` is 0.
- R6: While busy, `rd_data_o[6]` is 0 on the first cycle after start. It inverts after each cycle in which `rd_i` is 1, and holds otherwise.
- R7: While busy, `rd_data_o[5:0]` is 0.
- R8: `done_o` is high for exactly the one cycle after `busy_o` falls. From then on reads return true array data and bit 6 no longer changes.
- R9: A start pulse while busy is ignored. The captured operation, the captured bit and the remaining duration are unchanged, and the toggle bit is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_erase_i | input | 1 | Operation kind at start: 0 program, 1 erase |
| prog_msb_i | input | 1 | Bit 7 of the byte being programmed, sampled at start |
| rd_i | input | 1 | Read strobe, one per cycle |
| array_data_i | input | 8 | Data from the array for the current read |
| rd_data_o | output | 8 | Read data: array data when idle, status byte when busy |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the operation ends |

## Verification
The bench builds the block with PROG_CYCLES = 5 and ERASE_CYCLES = 12. These are short enough that every busy cycle of every operation is read and checked. They also differ, so a program timed with the erase length, or the reverse, shows up as a wrong busy length. The odd program length makes the toggle parity at the end of a program differ from that of an erase. A start pulse placed mid-program then shows whether the window was restarted or taken as an erase.

// File: rtl/emb_op_pkg.sv
// Package: shared types and the status byte builder for the busy-status monitor.
// Assumes: bit 7 is the polling bit, bit 6 the toggle bit, the rest read as zero.
package emb_op_pkg;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    // Build the byte a host sees while an operation is running.
    function automatic logic [7:0] busy_status(input op_kind_e kind,
                                               input logic     msb,
                                               input logic     tgl);
        logic poll;
        poll = (kind == OP_ERASE) ? 1'b0 : ~msb;
        return {poll, tgl, 6'b000000};
    endfunction

endpackage

// File: rtl/emb_op_timer.sv
// Module: internal duration counter. It accepts a start only while idle and
// holds busy for exactly the parameter's number of cycles for the selected kind.
// Assumes: both durations are at least 1 cycle.
module emb_op_timer #(
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic erase_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    // Start is taken only when no operation is running.
    assign accept_o = start_i && !busy_q;

    // Load, count down and retire the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= erase_i ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= CNT_W'(MAX_CYC - 1))); // R3
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8

endmodule

// File: rtl/emb_op_toggle.sv
// Module: toggle-bit flop. It clears on an accepted start and inverts once per
// read strobe while busy.
// Assumes: the clear and a read never both matter in one cycle, because an accepted start implies idle.
module emb_op_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic busy_i,
    input  logic rd_i,
    output logic tgl_o
);
    logic tgl_q;

    // Clear at start, flip on each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (clear_i) begin
            tgl_q <= 1'b0;
        end else if (busy_i && rd_i) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign tgl_o = tgl_q;

    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !(busy_i && rd_i)) |=> $stable(tgl_q)); // R6

endmodule

// File: rtl/emb_op_status.sv
// Module: top of the busy-status monitor. It captures the operation kind and
// the programmed top bit at an accepted start. While busy it substitutes the
// status byte for array data on the read path.
// Assumes: array_data_i is valid in the same cycle as rd_i, and the read path is combinational.
module emb_op_status #(
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       op_erase_i,
    input  logic       prog_msb_i,
    input  logic       rd_i,
    input  logic [7:0] array_data_i,
    output logic [7:0] rd_data_o,
    output logic       busy_o,
    output logic       done_o
);
    import emb_op_pkg::*;

    logic     accept;
    logic     busy;
    logic     tgl;
    op_kind_e kind_q;
    logic     msb_q;

    emb_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .erase_i (op_erase_i),
        .accept_o(accept),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    emb_op_toggle toggle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(accept),
        .busy_i (busy),
        .rd_i   (rd_i),
        .tgl_o  (tgl)
    );

    // Capture the operation context at an accepted start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_PROGRAM;
            msb_q  <= 1'b0;
        end else if (accept) begin
            kind_q <= op_kind_e'(op_erase_i);
            msb_q  <= prog_msb_i;
        end
    end

    // Choose between the status byte and true array data.
    always_comb begin
        rd_data_o = busy ? busy_status(kind_q, msb_q, tgl) : array_data_i;
    end

    assign busy_o = busy;

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> ($stable(msb_q) && $stable(kind_q))); // R9
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rd_data_o[5:0] == 6'd0)); // R7
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && kind_q == OP_ERASE) |-> !rd_data_o[7]); // R5
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rd_i) |=> (!busy_o || (rd_data_o[6] != $past(rd_data_o[6])))); // R6

endmodule

// File: tb/emb_op_status_tb_top.sv
module emb_op_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_N     = 5;
    localparam int ERASE_N    = 12;
    localparam int NVEC       = 5;
    // Vector fields: {erase, prog_msb, array_data[7:0]}
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b0, 8'h3C},
        {1'b1, 1'b0, 8'hFF},
        {1'b1, 1'b1, 8'h42},
        {1'b0, 1'b1, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_erase_i = 1'b0;
    logic       prog_msb_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] array_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       busy_o;
    logic       done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    emb_op_status #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .prog_msb_i(prog_msb_i), .rd_i(rd_i), .array_data_i(array_data_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic er, input logic msb);
        @(negedge clk);
        start_i = 1'b1; op_erase_i = er; prog_msb_i = msb; rd_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 busy", {7'd0, busy_o}, 8'h00);
        check("R1 done", {7'd0, done_o}, 8'h00);
        rst_n = 1'b1;
        // R2: idle pass-through for several patterns
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            rd_i = 1'b1; array_data_i = 8'h5A ^ 8'(v * 37);
            #1 check("R2 idle read", rd_data_o, 8'h5A ^ 8'(v * 37));
        end
        // Table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            int n;
            logic er, msb;
            logic [7:0] ad;
            {er, msb, ad} = VEC[i];
            n = er ? ERASE_N : PROG_N;
            start_op(er, msb);
            for (int k = 0; k < n; k++) begin
                rd_i = 1'b1; array_data_i = ad;
                #1;
                check("R3 busy held", {7'd0, busy_o}, 8'h01);
                check("R4 R5 R6 R7 status", rd_data_o,
                      {er ? 1'b0 : ~msb, 1'(k % 2), 6'd0});
                @(negedge clk);
            end
            #1;
            check("R3 busy ends", {7'd0, busy_o}, 8'h00);
            check("R8 done pulse", {7'd0, done_o}, 8'h01);
            check("R8 true data", rd_data_o, ad);
            @(negedge clk);
            #1;
            check("R8 done single", {7'd0, done_o}, 8'h00);
            check("R8 bit6 stopped", rd_data_o, ad);
            rd_i = 1'b0;
        end
        // R6: cycles without a read hold the toggle
        start_op(1'b0, 1'b1);
        rd_i = 1'b1; #1 check("R6 first read", rd_data_o, 8'h00);
        @(negedge clk); rd_i = 1'b0; #1 check("R6 after one read", rd_data_o, 8'h40);
        @(negedge clk); rd_i = 1'b1; #1 check("R6 held without read", rd_data_o, 8'h40);
        repeat (3) @(negedge clk);
        rd_i = 1'b0;
        #1 check("R3 idle again", {7'd0, busy_o}, 8'h00);
        // R9: start while busy is ignored
        start_op(1'b0, 1'b0);
        rd_i = 1'b1; array_data_i = 8'hC3;
        #1 check("R9 initial status", rd_data_o, 8'h80);
        @(negedge clk);
        start_i = 1'b1; op_erase_i = 1'b1; prog_msb_i = 1'b1;
        #1 check("R9 before ignored start", rd_data_o, 8'hC0);
        @(negedge clk);
        start_i = 1'b0;
        #1 check("R9 kind and toggle kept", rd_data_o, 8'h80);
        @(negedge clk); #1 check("R9 still busy", {7'd0, busy_o}, 8'h01);
        @(negedge clk); #1 check("R9 last busy", {7'd0, busy_o}, 8'h01);
        @(negedge clk); #1 check("R9 ends on program length", {7'd0, busy_o}, 8'h00);
        check("R9 done", {7'd0, done_o}, 8'h01);
        rd_i = 1'b0;
        // R1: reset mid-operation returns to idle
        start_op(1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        array_data_i = 8'h9E; #1;
        check("R1 reset busy", {7'd0, busy_o}, 8'h00);
        check("R1 reset read", rd_data_o, 8'h9E);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule